// File: doc/BRIEF.md
# Multi-Channel Frame Alignment Reset Controller

This block supervises four byte-wide tributary channels, each of which delivers its own frame-start pulse. It checks whether all four pulses land on one and the same enabled clock cycle. When no such coincidence turns up inside a timeout window, it pulls an active-low synchronous reset to the four upstream framers and holds it for a fixed number of cycles. It then stops the tributary transmit clock for a further fixed number of cycles and restarts it. Because the upstream devices leave reset together and see their first clock edge together, they start in step.

The block runs on one clock with a free-running enable (`clk_en`) that marks tributary-rate cycles. Every window, hold and timeout counts enabled cycles only. The hold counters therefore keep running while the gated tributary clock is stopped. After the clock restarts, a new search begins. If that search also fails, the whole sequence repeats. Once the four pulses coincide, the block reports alignment. It keeps watching for a late or skewed pulse, and either one sends it back to searching. A per-channel bitmap records which channels pulsed during the current search window, for diagnostics.

With the default parameters, a 77.76 MHz tributary rate gives a 250 us window of 19,440 cycles. Both holds default to 16 cycles.

Top module: `frame_align_rstctl`

## Requirements
- R1: While `rst` is high and after it is released, `sync_rst_n`=1, `clk_run`=1, `aligned`=0 and `pulse_seen`=0, and a search window of TIMEOUT_CYC enabled cycles starts.
- R2: If no enabled cycle of a search window has all four bits of `fp_in` high, `sync_rst_n` drops to 0 on exactly the TIMEOUT_CYC-th enabled edge of the window, and not before.
- R3: `sync_rst_n` stays 0 for exactly RST_HOLD_CYC enabled edges, and `clk_run` is 0 the whole time.
- R4: After `sync_rst_n` returns to 1, `clk_run` stays 0 for exactly CLK_HOLD_CYC enabled edges, then returns to 1 and a new search window starts.
- R5: An enabled cycle in search with `fp_in` all ones sets `aligned` after that edge. Pulses that reach every channel but on different cycles do not align.
- R6: While aligned, a coincident pulse restarts the TIMEOUT_CYC window. A cycle with some but not all pulse bits high, or a full window without a coincidence, clears `aligned` and starts a new search.
- R7: Bit i of `pulse_seen` (bit 0 = channel 0) is the OR of `fp_in[i]` over the enabled cycles of the current search window. It is cleared whenever a search window starts and holds its value outside search.
- R8: On a cycle with `clk_en`=0, no output, timer or bitmap changes, and `fp_in` is ignored.
- R9: Frame pulses are ignored during both the reset hold and the clock hold.
- R10: A search that fails after a restart runs the reset and clock-hold sequence again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Free-running tributary-rate cycle enable |
| fp_in | input | NUM_CH | Frame pulse, one bit per channel |
| sync_rst_n | output | 1 | Active-low synchronous reset to the upstream framers |
| clk_run | output | 1 | 1 lets the tributary transmit clock run |
| aligned | output | 1 | All channels are frame-aligned |
| pulse_seen | output | NUM_CH | Channels that pulsed in the current search window |

## Verification
The checker enforces several rules on every cycle:
- the clock is stopped whenever the reset is low;
- alignment is only reported with the clock running and the reset released;
- each hold lasts at least its minimum count of enabled cycles;
- alignment only begins right after an enabled all-ones pulse;
- nothing moves on a disabled cycle;
- the bitmap is empty whenever the clock restarts.

The exact cycle on which the timeout fires, the restart of the aligned window by a coincidence, and the loss of alignment on a skewed or missing pulse are shown only by the bench's scenarios. So are the repeat of the sequence and the fact that pulses are ignored during the holds.

// File: rtl/frame_align_pkg.sv
package frame_align_pkg;

    typedef enum logic [1:0] {
        ST_SEARCH   = 2'd0,
        ST_RST_HOLD = 2'd1,
        ST_CLK_HOLD = 2'd2,
        ST_LOCKED   = 2'd3
    } align_state_e;

    // Pulse classification for one cycle
    typedef struct packed {
        logic all_hit;   // every channel pulsed
        logic part_hit;  // some, but not all, channels pulsed
    } coinc_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int cnt_width(input int a, input int b, input int c);
        return $clog2(max3(a, b, c) + 1);
    endfunction

endpackage

// File: rtl/fa_pulse_tracker.sv
module fa_pulse_tracker
    import frame_align_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              clear,
    input  logic              accum,
    input  logic [NUM_CH-1:0] fp_in,
    output coinc_t            hit,
    output logic [NUM_CH-1:0] seen
);

    assign hit.all_hit  = &fp_in;
    assign hit.part_hit = (|fp_in) & ~(&fp_in);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                seen[i] <= 1'b0;
            end else if (en) begin
                if (clear)
                    seen[i] <= 1'b0;
                else if (accum && fp_in[i])
                    seen[i] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/fa_window_counter.sv
module fa_window_counter #(
    parameter int CW      = 15,
    parameter int INIT_VAL = 100
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);

    localparam logic [CW-1:0] INIT_W = CW'(INIT_VAL);
    localparam logic [CW-1:0] ONE_W  = CW'(1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= INIT_W;
        end else if (en) begin
            if (load)
                cnt <= load_val;
            else if (cnt != '0)
                cnt <= cnt - ONE_W;
        end
    end

    // Final cycle of the current window
    assign last = (cnt == ONE_W);

endmodule

// File: rtl/fa_seq_fsm.sv
module fa_seq_fsm
    import frame_align_pkg::*;
#(
    parameter int TIMEOUT_CYC  = 19440,
    parameter int RST_HOLD_CYC = 16,
    parameter int CLK_HOLD_CYC = 16,
    parameter int CW           = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  coinc_t        hit,
    input  logic          last,
    output align_state_e  state,
    output logic          load,
    output logic [CW-1:0] load_val,
    output logic          clear_seen
);

    localparam logic [CW-1:0] LV_WIN = CW'(TIMEOUT_CYC);
    localparam logic [CW-1:0] LV_RST = CW'(RST_HOLD_CYC);
    localparam logic [CW-1:0] LV_CLK = CW'(CLK_HOLD_CYC);

    align_state_e nxt;

    always_comb begin
        nxt        = state;
        load       = 1'b0;
        load_val   = LV_WIN;
        clear_seen = 1'b0;
        if (en) begin
            unique case (state)
                ST_SEARCH: begin
                    if (hit.all_hit) begin
                        nxt  = ST_LOCKED;
                        load = 1'b1;
                    end else if (last) begin
                        nxt      = ST_RST_HOLD;
                        load     = 1'b1;
                        load_val = LV_RST;
                    end
                end
                ST_RST_HOLD: begin
                    if (last) begin
                        nxt      = ST_CLK_HOLD;
                        load     = 1'b1;
                        load_val = LV_CLK;
                    end
                end
                ST_CLK_HOLD: begin
                    if (last) begin
                        nxt        = ST_SEARCH;
                        load       = 1'b1;
                        clear_seen = 1'b1;
                    end
                end
                ST_LOCKED: begin
                    if (hit.all_hit) begin
                        load = 1'b1;
                    end else if (hit.part_hit || last) begin
                        nxt        = ST_SEARCH;
                        load       = 1'b1;
                        clear_seen = 1'b1;
                    end
                end
                default: nxt = ST_SEARCH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_SEARCH;
        else
            state <= nxt;
    end

endmodule

// File: rtl/frame_align_rstctl.sv
module frame_align_rstctl
    import frame_align_pkg::*;
#(
    parameter int NUM_CH       = 4,
    parameter int TIMEOUT_CYC  = 19440,
    parameter int RST_HOLD_CYC = 16,
    parameter int CLK_HOLD_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic [NUM_CH-1:0] fp_in,
    output logic              sync_rst_n,
    output logic              clk_run,
    output logic              aligned,
    output logic [NUM_CH-1:0] pulse_seen
);

    localparam int CW = cnt_width(TIMEOUT_CYC, RST_HOLD_CYC, CLK_HOLD_CYC);

    align_state_e  state;
    coinc_t        hit;
    logic          last;
    logic          load;
    logic [CW-1:0] load_val;
    logic          clear_seen;

    fa_pulse_tracker #(.NUM_CH(NUM_CH)) u_track (
        .clk   (clk),
        .rst   (rst),
        .en    (clk_en),
        .clear (clear_seen),
        .accum (state == ST_SEARCH),
        .fp_in (fp_in),
        .hit   (hit),
        .seen  (pulse_seen)
    );

    fa_window_counter #(.CW(CW), .INIT_VAL(TIMEOUT_CYC)) u_win (
        .clk      (clk),
        .rst      (rst),
        .en       (clk_en),
        .load     (load),
        .load_val (load_val),
        .last     (last)
    );

    fa_seq_fsm #(
        .TIMEOUT_CYC  (TIMEOUT_CYC),
        .RST_HOLD_CYC (RST_HOLD_CYC),
        .CLK_HOLD_CYC (CLK_HOLD_CYC),
        .CW           (CW)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .en         (clk_en),
        .hit        (hit),
        .last       (last),
        .state      (state),
        .load       (load),
        .load_val   (load_val),
        .clear_seen (clear_seen)
    );

    assign sync_rst_n = (state != ST_RST_HOLD);
    assign clk_run    = (state == ST_SEARCH) || (state == ST_LOCKED);
    assign aligned    = (state == ST_LOCKED);

endmodule

// File: rtl/fa_align_checker.sv
module fa_align_checker #(
    parameter int NUM_CH       = 4,
    parameter int RST_HOLD_CYC = 16,
    parameter int CLK_HOLD_CYC = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              clk_en,
    input logic [NUM_CH-1:0] fp_in,
    input logic              sync_rst_n,
    input logic              clk_run,
    input logic              aligned,
    input logic [NUM_CH-1:0] pulse_seen
);

    logic [31:0] low_cnt;
    logic [31:0] stop_cnt;

    always_ff @(posedge clk) begin
        if (rst || sync_rst_n)
            low_cnt <= '0;
        else if (clk_en)
            low_cnt <= low_cnt + 32'd1;
    end

    always_ff @(posedge clk) begin
        if (rst || clk_run)
            stop_cnt <= '0;
        else if (clk_en && sync_rst_n)
            stop_cnt <= stop_cnt + 32'd1;
    end

    AST_RST_STOPS_CLK: assert property (@(posedge clk) disable iff (rst)
        !sync_rst_n |-> !clk_run);  // R3

    AST_LOCK_CLEAN: assert property (@(posedge clk) disable iff (rst)
        aligned |-> (clk_run && sync_rst_n));  // R5

    AST_RST_MIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($rose(sync_rst_n) && !$past(rst)) |-> (low_cnt >= 32'(RST_HOLD_CYC)));  // R3

    AST_CLK_MIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($rose(clk_run) && !$past(rst)) |-> (stop_cnt >= 32'(CLK_HOLD_CYC)));  // R4

    AST_RST_FROM_SEARCH: assert property (@(posedge clk) disable iff (rst)
        $fell(sync_rst_n) |-> ($past(clk_run) && !$past(aligned)));  // R2

    AST_LOCK_NEEDS_COINC: assert property (@(posedge clk) disable iff (rst)
        $rose(aligned) |-> (($past(fp_in) == '1) && $past(clk_en)));  // R5

    AST_IDLE_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> ($stable(sync_rst_n) && $stable(clk_run)
                     && $stable(aligned) && $stable(pulse_seen)));  // R8

    AST_SEEN_CLEAR_ON_RESTART: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_run) |-> (pulse_seen == '0));  // R7

endmodule

bind frame_align_rstctl fa_align_checker #(
    .NUM_CH       (NUM_CH),
    .RST_HOLD_CYC (RST_HOLD_CYC),
    .CLK_HOLD_CYC (CLK_HOLD_CYC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clk_en     (clk_en),
    .fp_in      (fp_in),
    .sync_rst_n (sync_rst_n),
    .clk_run    (clk_run),
    .aligned    (aligned),
    .pulse_seen (pulse_seen)
);

// File: tb/frame_align_rstctl_test.sv
`timescale 1ns/100ps
module frame_align_rstctl_test;

    localparam int N  = 4;
    localparam int T  = 40;
    localparam int RH = 16;
    localparam int CH = 16;

    logic         clk    = 1'b0;
    logic         rst    = 1'b1;
    logic         clk_en = 1'b1;
    logic [N-1:0] fp_in  = '0;
    logic         sync_rst_n;
    logic         clk_run;
    logic         aligned;
    logic [N-1:0] pulse_seen;

    always #2.5 clk = ~clk;

    frame_align_rstctl #(
        .NUM_CH(N), .TIMEOUT_CYC(T), .RST_HOLD_CYC(RH), .CLK_HOLD_CYC(CH)
    ) uut (
        .clk(clk), .rst(rst), .clk_en(clk_en), .fp_in(fp_in),
        .sync_rst_n(sync_rst_n), .clk_run(clk_run),
        .aligned(aligned), .pulse_seen(pulse_seen)
    );

    typedef struct packed {
        logic         rn;
        logic         run;
        logic         al;
        logic [N-1:0] seen;
        logic         cs;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks   = 0;
    int    failures = 0;
    bit    finished = 0;

    // Driver helpers: a tick applies fp for one edge, then lands just after it
    task automatic tick(input logic [N-1:0] fp);
        fp_in = fp;
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n, input logic [N-1:0] fp);
        for (int i = 0; i < n; i++) tick(fp);
    endtask

    task automatic expect_out(input logic rn, input logic run, input logic al,
                              input logic [N-1:0] seen, input logic cs,
                              input string tag);
        exp_t e;
        e.rn = rn; e.run = run; e.al = al; e.seen = seen; e.cs = cs;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare queued expectations at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (sync_rst_n !== e.rn || clk_run !== e.run || aligned !== e.al ||
                    (e.cs && pulse_seen !== e.seen)) begin
                    failures++;
                    $display("FAIL %s: got rst_n=%b run=%b aligned=%b seen=%b expected rst_n=%b run=%b aligned=%b seen=%b",
                             t, sync_rst_n, clk_run, aligned, pulse_seen,
                             e.rn, e.run, e.al, e.seen);
                end
            end
        end
    end

    initial begin
        #(100000 * 5);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        ticks(3, '0);
        expect_out(1, 1, 0, 4'b0000, 1, "R1 during reset");
        rst = 1'b0;
        tick('0);
        expect_out(1, 1, 0, 4'b0000, 1, "R1 after reset");

        // Disabled cycles: coincident pulses and elapsed time ignored (R8)
        clk_en = 1'b0;
        ticks(T + 5, 4'b1111);
        expect_out(1, 1, 0, 4'b0000, 1, "R8 pulses ignored while disabled");
        clk_en = 1'b1;

        // The tick right after release was window cycle 1; continue the window
        tick(4'b0101);                                   // cycle 2
        expect_out(1, 1, 0, 4'b0101, 1, "R7 bitmap accumulates");
        tick(4'b1010);                                   // cycle 3
        expect_out(1, 1, 0, 4'b1111, 1, "R5 skewed pulses do not align");
        ticks(T - 4, 4'b0000);                           // cycle T-1
        expect_out(1, 1, 0, 4'b1111, 1, "R2 no early timeout, R8 timer frozen");
        tick(4'b0000);                                   // cycle T
        expect_out(0, 0, 0, 4'b1111, 1, "R2 timeout drives reset low");

        // Reset hold, with pulses applied (R3, R9)
        ticks(RH - 1, 4'b1111);
        expect_out(0, 0, 0, 4'b1111, 1, "R3 reset still held, R9 pulses ignored");
        tick(4'b1111);
        expect_out(1, 0, 0, 4'b1111, 1, "R3 reset released after hold");

        // Clock hold (R4, R9)
        ticks(CH - 1, 4'b1111);
        expect_out(1, 0, 0, 4'b1111, 1, "R4 clock still stopped, R9 pulses ignored");
        tick(4'b0000);
        expect_out(1, 1, 0, 4'b0000, 1, "R4 clock restarts, R7 bitmap cleared");

        // Alignment (R5)
        tick(4'b0011);
        expect_out(1, 1, 0, 4'b0011, 1, "R7 partial pulses recorded");
        tick(4'b1111);
        expect_out(1, 1, 1, 4'b1111, 1, "R5 coincidence aligns");

        // Aligned window and reload (R6)
        ticks(T - 1, 4'b0000);
        expect_out(1, 1, 1, 4'b1111, 1, "R6 aligned within window");
        tick(4'b1111);
        expect_out(1, 1, 1, 4'b1111, 1, "R6 coincidence keeps alignment");
        ticks(T - 1, 4'b0000);
        expect_out(1, 1, 1, 4'b1111, 1, "R6 window reloaded by coincidence");
        tick(4'b0110);
        expect_out(1, 1, 0, 4'b0000, 1, "R6 skewed pulse drops alignment, R7 clear");

        // Missing pulse drops alignment (R6)
        tick(4'b1111);
        expect_out(1, 1, 1, 4'b1111, 1, "R5 realign");
        ticks(T - 1, 4'b0000);
        expect_out(1, 1, 1, 4'b1111, 1, "R6 still aligned before window end");
        tick(4'b0000);
        expect_out(1, 1, 0, 4'b0000, 1, "R6 missing pulse drops alignment");

        // Failed search repeats the sequence (R10)
        ticks(T - 1, 4'b1000);
        expect_out(1, 1, 0, 4'b1000, 1, "R10 searching again");
        tick(4'b0000);
        expect_out(0, 0, 0, 4'b1000, 1, "R10 sequence repeats");
        ticks(RH, 4'b0000);
        expect_out(1, 0, 0, 4'b1000, 1, "R10 second reset release");

        // Reset mid-sequence returns to the idle state (R1)
        rst = 1'b1;
        tick(4'b0000);
        rst = 1'b0;
        expect_out(1, 1, 0, 4'b0000, 1, "R1 reset from clock hold");

        repeat (2) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule